// File: doc/BRIEF.md
# Trap Entry and Return State Unit

This unit holds a hart's current privilege level and the machine state that trap entry and trap return touch. That state is the two interrupt-enable stacks, the previous-privilege fields, the modify-privilege bit, and one cause/PC/value register set for each of the Machine and Supervisor handler levels. The pipeline raises one single-cycle request: a trap (a synchronous exception or an interrupt), a return from Machine level, or a return from Supervisor level.

For a trap, the unit picks the handling level from a delegation mask indexed by the exception code. For an interrupt, it takes a delegation hint from the interrupt dispatcher. It never hands a trap to a level below the one currently running. All state commits on the clock edge that samples the request. On that same edge a one-cycle redirect pulse tells the fetch stage whether to go to a trap vector or to a saved return address, and at which level.

Vector address computation and general register read/write access are outside the block. The only writes it takes are a whole-mask load of the delegation mask and a single-bit write of the modify-privilege bit.

Top module: `trap_state_unit`

## Requirements
- R1: After reset the outputs read as follows. `priv` is Machine, `st_mie`, `st_mpie`, `st_mprv`, `st_sie`, `st_spie` and `st_spp` are 0, and `st_mpp` is Machine. `mcause` and all other save registers are 0, `redir_valid` is 0, `pc_reset` equals `RESET_PC`, and the delegation mask is all zeros. Privilege encoding is User=2'b00, Supervisor=2'b01, Machine=2'b11.
- R2: Choosing the level for an exception: it targets Supervisor when S-mode is present and bit `trap_code` of the delegation mask is 1. The mask is loaded whole by a `deleg_load` pulse carrying `deleg_value`. Otherwise the exception targets Machine. For an interrupt (`trap_irq`=1), the `irq_to_s` input takes the place of the mask bit.
- R3: When the target is Supervisor but the current level is Machine, the trap is taken at Machine.
- R4: A trap taken at Machine updates state as follows. `mcause` becomes {`trap_irq` in bit XLEN-1, zeros, `trap_code` in the low CODE_W bits}. MPIE takes the old MIE, MIE is cleared, MPP takes the old privilege, `mtval` takes the trap value, `mepc` takes `trap_pc`, and `priv` becomes Machine.
- R5: A trap taken at Supervisor updates state as follows. `scause` is built the same way as in R4. SPIE takes the old SIE and SIE is cleared. SPP becomes 1 if the trap came from Supervisor and 0 if it came from User. `stval` takes the trap value, `sepc` takes `trap_pc`, and `priv` becomes Supervisor.
- R6: The trap value is `trap_info` when `trap_has_info` is 1, and zero otherwise.
- R7: A Machine return makes these changes. MIE takes MPIE and MPIE becomes 1. `priv` takes the old MPP. MPP becomes User (Machine if User mode is absent). MPRV is cleared unless the new level is Machine.
- R8: A Supervisor return makes these changes. SIE takes SPIE and SPIE becomes 1. `priv` becomes Supervisor if the old SPP was 1 and User otherwise. SPP is cleared and MPRV is cleared.
- R9: One cycle after a trap or return request, `redir_valid` is 1 for exactly one cycle. With it, `redir_vector` is 1 for a trap and 0 for a return. `redir_level` gives the handling level for a trap, Machine for a Machine return, and Supervisor for a Supervisor return. At most one request is high in any cycle.
- R10: An `mprv_wr` pulse loads `mprv_val` into MPRV one cycle later. Traps leave MPRV unchanged.
- R11: A trap taken at one level leaves the other level's cause, PC and value registers unchanged, and it leaves the other level's enable and previous-privilege bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request pulse |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_has_info | input | 1 | Trap value accompanies the trap |
| trap_info | input | XLEN | Trap value |
| irq_to_s | input | 1 | Dispatcher chose Supervisor for this interrupt |
| mret_req | input | 1 | Machine return pulse |
| sret_req | input | 1 | Supervisor return pulse |
| deleg_load | input | 1 | Load delegation mask |
| deleg_value | input | 2**CODE_W | New delegation mask |
| mprv_wr | input | 1 | Write the modify-privilege bit |
| mprv_val | input | 1 | Value for the modify-privilege bit |
| priv | output | 2 | Current privilege level |
| st_mie | output | 1 | Machine interrupt enable |
| st_mpie | output | 1 | Machine previous interrupt enable |
| st_mpp | output | 2 | Machine previous privilege |
| st_sie | output | 1 | Supervisor interrupt enable |
| st_spie | output | 1 | Supervisor previous interrupt enable |
| st_spp | output | 1 | Supervisor previous privilege |
| st_mprv | output | 1 | Modify-privilege bit |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| pc_reset | output | XLEN | Reset PC |
| redir_valid | output | 1 | Redirect pulse |
| redir_vector | output | 1 | 1 = trap vector, 0 = return address |
| redir_level | output | 2 | Level of the vector or return register |

## Verification
Every result of a request is registered once. The privilege, the stack bits, the save registers and the redirect pulse all appear at the first clock edge after the cycle the request is held high, and the redirect drops again one edge later. The driver raises each request just after a falling edge and pushes the expected state, computed from its own privilege model, into a queue. The monitor compares the outputs at the next falling edge, where it sees `redir_valid`, and the driver confirms at the falling edge after that that the pulse is gone. The modify-privilege load and the delegation load produce no redirect, so their single-cycle effect is checked directly at the falling edge after the write.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_M = 2'b11
  } priv_t;

  // Never let a delegated trap land below the running level.
  function automatic priv_t clamp_target(priv_t want, priv_t cur);
    return (want < cur) ? cur : want;
  endfunction

  // Level reached by a Machine return, read from the saved field.
  function automatic priv_t mret_dest(priv_t saved);
    return saved;
  endfunction

  // Level reached by a Supervisor return.
  function automatic priv_t sret_dest(logic spp);
    return spp ? PRV_S : PRV_U;
  endfunction

  // Saved-previous-privilege bit for a Supervisor trap.
  function automatic logic spp_of(priv_t from);
    return (from == PRV_S);
  endfunction

endpackage

// File: rtl/trap_deleg.sv
module trap_deleg
  import trap_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter bit HAS_S   = 1'b1,
  localparam int DELEG_W = 1 << CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DELEG_W-1:0] value,
  input  logic               trap_irq,
  input  logic               irq_to_s,
  input  logic [CODE_W-1:0]  code,
  input  priv_t              cur_priv,
  output priv_t              tgt_priv
);

  logic [DELEG_W-1:0] mask_q;
  logic               want_s;
  priv_t              want_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (load) mask_q <= value;
  end

  assign want_s   = HAS_S && (trap_irq ? irq_to_s : mask_q[code]);
  assign want_lvl = want_s ? PRV_S : PRV_M;
  assign tgt_priv = clamp_target(want_lvl, cur_priv);

endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter bit HAS_U = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_m,
  input  logic  trap_s,
  input  logic  do_mret,
  input  logic  do_sret,
  input  logic  mprv_wr,
  input  logic  mprv_val,
  output priv_t priv_q,
  output logic  mie_q,
  output logic  mpie_q,
  output priv_t mpp_q,
  output logic  sie_q,
  output logic  spie_q,
  output logic  spp_q,
  output logic  mprv_q
);

  localparam priv_t MPP_AFTER_RET = HAS_U ? PRV_U : PRV_M;

  priv_t mret_lvl;
  priv_t sret_lvl;

  assign mret_lvl = mret_dest(mpp_q);
  assign sret_lvl = sret_dest(spp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= PRV_M;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      mpp_q  <= PRV_M;
      sie_q  <= 1'b0;
      spie_q <= 1'b0;
      spp_q  <= 1'b0;
      mprv_q <= 1'b0;
    end else if (trap_m) begin
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      mpp_q  <= priv_q;
      priv_q <= PRV_M;
    end else if (trap_s) begin
      spie_q <= sie_q;
      sie_q  <= 1'b0;
      spp_q  <= spp_of(priv_q);
      priv_q <= PRV_S;
    end else if (do_mret) begin
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      priv_q <= mret_lvl;
      mpp_q  <= MPP_AFTER_RET;
      if (mret_lvl != PRV_M) mprv_q <= 1'b0;
    end else if (do_sret) begin
      sie_q  <= spie_q;
      spie_q <= 1'b1;
      priv_q <= sret_lvl;
      spp_q  <= 1'b0;
      mprv_q <= 1'b0;
    end else if (mprv_wr) begin
      mprv_q <= mprv_val;
    end
  end

  AST_TRAP_M_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_m |=> (!mie_q && mpie_q == $past(mie_q) && mpp_q == $past(priv_q) && priv_q == PRV_M)); // R4
  AST_TRAP_S_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_s |=> (!sie_q && spie_q == $past(sie_q) && spp_q == ($past(priv_q) == PRV_S) && priv_q == PRV_S)); // R5
  AST_S_NOT_FROM_M: assert property (@(posedge clk) disable iff (!rst_n)
    trap_s |-> priv_q != PRV_M); // R3
  AST_MRET_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    do_mret |=> (mie_q == $past(mpie_q) && mpie_q && priv_q == $past(mpp_q))); // R7
  AST_SRET_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    do_sret |=> (sie_q == $past(spie_q) && spie_q && !spp_q && !mprv_q)); // R8
  AST_TRAP_KEEPS_MPRV: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_m || trap_s) |=> mprv_q == $past(mprv_q)); // R10
  AST_M_TRAP_KEEPS_S: assert property (@(posedge clk) disable iff (!rst_n)
    trap_m |=> (sie_q == $past(sie_q) && spie_q == $past(spie_q) && spp_q == $past(spp_q))); // R11

endmodule

// File: rtl/trap_save.sv
module trap_save #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              irq,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc,
  input  logic              has_info,
  input  logic [XLEN-1:0]   info,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   tval_q
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  function automatic logic [XLEN-1:0] make_cause(logic is_irq, logic [CODE_W-1:0] c);
    return {is_irq, {PAD_W{1'b0}}, c};
  endfunction

  function automatic logic [XLEN-1:0] trap_value(logic present, logic [XLEN-1:0] v);
    return present ? v : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
      tval_q  <= '0;
    end else if (wr) begin
      cause_q <= make_cause(irq, code);
      epc_q   <= pc;
      tval_q  <= trap_value(has_info, info);
    end
  end

  AST_TVAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !has_info) |=> tval_q == '0); // R6
  AST_SAVE_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> epc_q == $past(pc)); // R4
  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(cause_q) && $stable(epc_q) && $stable(tval_q))); // R11

endmodule

// File: rtl/trap_state_unit.sv
module trap_state_unit
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 5,
  parameter bit              HAS_S    = 1'b1,
  parameter bit              HAS_U    = 1'b1,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000,
  localparam int             DELEG_W  = 1 << CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CODE_W-1:0]  trap_code,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               trap_has_info,
  input  logic [XLEN-1:0]    trap_info,
  input  logic               irq_to_s,
  input  logic               mret_req,
  input  logic               sret_req,
  input  logic               deleg_load,
  input  logic [DELEG_W-1:0] deleg_value,
  input  logic               mprv_wr,
  input  logic               mprv_val,
  output logic [1:0]         priv,
  output logic               st_mie,
  output logic               st_mpie,
  output logic [1:0]         st_mpp,
  output logic               st_sie,
  output logic               st_spie,
  output logic               st_spp,
  output logic               st_mprv,
  output logic [XLEN-1:0]    mcause,
  output logic [XLEN-1:0]    mepc,
  output logic [XLEN-1:0]    mtval,
  output logic [XLEN-1:0]    scause,
  output logic [XLEN-1:0]    sepc,
  output logic [XLEN-1:0]    stval,
  output logic [XLEN-1:0]    pc_reset,
  output logic               redir_valid,
  output logic               redir_vector,
  output logic [1:0]         redir_level
);

  priv_t cur_priv;
  priv_t tgt_priv;
  priv_t mpp_lvl;
  priv_t redir_lvl_q;
  logic  trap_m;
  logic  trap_s;
  logic  do_mret;
  logic  do_sret;
  logic  any_event;

  assign trap_m    = trap_req && (tgt_priv == PRV_M);
  assign trap_s    = trap_req && (tgt_priv == PRV_S);
  assign do_mret   = mret_req;
  assign do_sret   = sret_req && HAS_S;
  assign any_event = trap_req || do_mret || do_sret;

  trap_deleg #(.CODE_W(CODE_W), .HAS_S(HAS_S)) u_deleg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (deleg_load),
    .value    (deleg_value),
    .trap_irq (trap_irq),
    .irq_to_s (irq_to_s),
    .code     (trap_code),
    .cur_priv (cur_priv),
    .tgt_priv (tgt_priv)
  );

  trap_status #(.HAS_U(HAS_U)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_m   (trap_m),
    .trap_s   (trap_s),
    .do_mret  (do_mret),
    .do_sret  (do_sret),
    .mprv_wr  (mprv_wr),
    .mprv_val (mprv_val),
    .priv_q   (cur_priv),
    .mie_q    (st_mie),
    .mpie_q   (st_mpie),
    .mpp_q    (mpp_lvl),
    .sie_q    (st_sie),
    .spie_q   (st_spie),
    .spp_q    (st_spp),
    .mprv_q   (st_mprv)
  );

  trap_save #(.XLEN(XLEN), .CODE_W(CODE_W)) u_msave (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (trap_m),
    .irq      (trap_irq),
    .code     (trap_code),
    .pc       (trap_pc),
    .has_info (trap_has_info),
    .info     (trap_info),
    .cause_q  (mcause),
    .epc_q    (mepc),
    .tval_q   (mtval)
  );

  generate
    if (HAS_S) begin : g_ssave
      trap_save #(.XLEN(XLEN), .CODE_W(CODE_W)) u_ssave (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (trap_s),
        .irq      (trap_irq),
        .code     (trap_code),
        .pc       (trap_pc),
        .has_info (trap_has_info),
        .info     (trap_info),
        .cause_q  (scause),
        .epc_q    (sepc),
        .tval_q   (stval)
      );
    end else begin : g_no_ssave
      assign scause = '0;
      assign sepc   = '0;
      assign stval  = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid  <= 1'b0;
      redir_vector <= 1'b0;
      redir_lvl_q  <= PRV_M;
    end else begin
      redir_valid  <= any_event;
      redir_vector <= trap_req;
      if (trap_req)      redir_lvl_q <= tgt_priv;
      else if (do_mret)  redir_lvl_q <= PRV_M;
      else if (do_sret)  redir_lvl_q <= PRV_S;
    end
  end

  assign priv        = cur_priv;
  assign st_mpp      = mpp_lvl;
  assign redir_level = redir_lvl_q;
  assign pc_reset    = RESET_PC;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_req, mret_req, sret_req})); // R9
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_event |=> (redir_valid && redir_vector == $past(trap_req))); // R9
  AST_REDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_event |=> !redir_valid); // R9
  AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (priv == redir_level)); // R2

endmodule

// File: tb/tb_trap_state_unit.sv
`timescale 1ns/1ps
module tb_trap_state_unit;

  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam logic [XLEN-1:0] RPC = 32'h0000_1000;
  localparam logic [1:0] LU = 2'b00, LS = 2'b01, LM = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 0, trap_irq = 0, trap_has_info = 0, irq_to_s = 0;
  logic [CW-1:0] trap_code = '0;
  logic [XLEN-1:0] trap_pc = '0, trap_info = '0;
  logic mret_req = 0, sret_req = 0, deleg_load = 0, mprv_wr = 0, mprv_val = 0;
  logic [31:0] deleg_value = '0;
  logic [1:0] priv, st_mpp, redir_level;
  logic st_mie, st_mpie, st_sie, st_spie, st_spp, st_mprv, redir_valid, redir_vector;
  logic [XLEN-1:0] mcause, mepc, mtval, scause, sepc, stval, pc_reset;

  always #2.5 clk = ~clk;

  trap_state_unit #(.XLEN(XLEN), .CODE_W(CW), .RESET_PC(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_code(trap_code), .trap_pc(trap_pc), .trap_has_info(trap_has_info),
    .trap_info(trap_info), .irq_to_s(irq_to_s), .mret_req(mret_req),
    .sret_req(sret_req), .deleg_load(deleg_load), .deleg_value(deleg_value),
    .mprv_wr(mprv_wr), .mprv_val(mprv_val), .priv(priv), .st_mie(st_mie),
    .st_mpie(st_mpie), .st_mpp(st_mpp), .st_sie(st_sie), .st_spie(st_spie),
    .st_spp(st_spp), .st_mprv(st_mprv), .mcause(mcause), .mepc(mepc),
    .mtval(mtval), .scause(scause), .sepc(sepc), .stval(stval),
    .pc_reset(pc_reset), .redir_valid(redir_valid), .redir_vector(redir_vector),
    .redir_level(redir_level)
  );

  typedef struct {
    logic [1:0] lv, mpp, rlv;
    logic mie, mpie, sie, spie, spp, mprv, vec;
    logic [XLEN-1:0] mc, me, mt, sc, se, st;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // reference model of the architectural state
  logic [1:0] r_lv = LM, r_mpp = LM;
  logic r_mie = 0, r_mpie = 0, r_sie = 0, r_spie = 0, r_spp = 0, r_mprv = 0;
  logic [XLEN-1:0] r_mc = 0, r_me = 0, r_mt = 0, r_sc = 0, r_se = 0, r_st = 0;
  logic [31:0] r_mask = 0;

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t snap(string tag, logic vec, logic [1:0] rlv);
    exp_t e;
    e.lv = r_lv; e.mpp = r_mpp; e.mie = r_mie; e.mpie = r_mpie;
    e.sie = r_sie; e.spie = r_spie; e.spp = r_spp; e.mprv = r_mprv;
    e.mc = r_mc; e.me = r_me; e.mt = r_mt; e.sc = r_sc; e.se = r_se; e.st = r_st;
    e.vec = vec; e.rlv = rlv; e.tag = tag;
    return e;
  endfunction

  // monitor: compare state once the redirect shows up
  always @(negedge clk) begin
    if (rst_n && redir_valid && !finished) begin
      if (q.size() == 0) chk("R9", "unexpected redirect", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "priv", XLEN'(priv), XLEN'(e.lv));
        chk(e.tag, "mie/mpie/mpp", XLEN'({st_mie, st_mpie, st_mpp}), XLEN'({e.mie, e.mpie, e.mpp}));
        chk(e.tag, "sie/spie/spp", XLEN'({st_sie, st_spie, st_spp}), XLEN'({e.sie, e.spie, e.spp}));
        chk(e.tag, "mprv", XLEN'(st_mprv), XLEN'(e.mprv));
        chk(e.tag, "mcause", mcause, e.mc);
        chk(e.tag, "mepc", mepc, e.me);
        chk(e.tag, "mtval", mtval, e.mt);
        chk(e.tag, "scause", scause, e.sc);
        chk(e.tag, "sepc", sepc, e.se);
        chk(e.tag, "stval", stval, e.st);
        chk("R9", "redir_vector", XLEN'(redir_vector), XLEN'(e.vec));
        chk("R9", "redir_level", XLEN'(redir_level), XLEN'(e.rlv));
      end
    end
  end

  task automatic pulse_gap();
    @(negedge clk);
    chk("R9", "redirect lasts one cycle", XLEN'(redir_valid), 0);
  endtask

  task automatic do_trap(string tag, logic irq, logic [CW-1:0] code, logic [XLEN-1:0] pc,
                         logic has, logic [XLEN-1:0] info, logic to_s);
    logic [1:0] tgt;
    logic go_s;
    go_s = irq ? to_s : r_mask[code];
    tgt = go_s ? LS : LM;
    if (tgt == LS && r_lv == LM) tgt = LM;
    if (tgt == LM) begin
      r_mc = {irq, 26'b0, code}; r_mpie = r_mie; r_mie = 0; r_mpp = r_lv;
      r_mt = has ? info : '0; r_me = pc; r_lv = LM;
    end else begin
      r_sc = {irq, 26'b0, code}; r_spie = r_sie; r_sie = 0; r_spp = (r_lv == LS);
      r_st = has ? info : '0; r_se = pc; r_lv = LS;
    end
    @(negedge clk);
    q.push_back(snap(tag, 1'b1, tgt));
    trap_req = 1; trap_irq = irq; trap_code = code; trap_pc = pc;
    trap_has_info = has; trap_info = info; irq_to_s = to_s;
    @(negedge clk);
    trap_req = 0; trap_irq = 0; trap_has_info = 0; irq_to_s = 0;
    pulse_gap();
  endtask

  task automatic do_mret(string tag);
    r_mie = r_mpie; r_mpie = 1; r_lv = r_mpp; r_mpp = LU;
    if (r_lv != LM) r_mprv = 0;
    @(negedge clk);
    q.push_back(snap(tag, 1'b0, LM));
    mret_req = 1;
    @(negedge clk);
    mret_req = 0;
    pulse_gap();
  endtask

  task automatic do_sret(string tag);
    r_sie = r_spie; r_spie = 1; r_lv = r_spp ? LS : LU; r_spp = 0; r_mprv = 0;
    @(negedge clk);
    q.push_back(snap(tag, 1'b0, LS));
    sret_req = 1;
    @(negedge clk);
    sret_req = 0;
    pulse_gap();
  endtask

  task automatic set_mprv(logic v);
    @(negedge clk);
    mprv_wr = 1; mprv_val = v;
    @(negedge clk);
    mprv_wr = 0;
    r_mprv = v;
    chk("R10", "mprv load", XLEN'(st_mprv), XLEN'(v));
  endtask

  task automatic load_mask(logic [31:0] m);
    @(negedge clk);
    deleg_load = 1; deleg_value = m;
    @(negedge clk);
    deleg_load = 0;
    r_mask = m;
    chk("R2", "mask load keeps priv", XLEN'(priv), XLEN'(r_lv));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset priv", XLEN'(priv), XLEN'(LM));
    chk("R1", "reset mie/mpie/mpp", XLEN'({st_mie, st_mpie, st_mpp}), XLEN'({2'b00, LM}));
    chk("R1", "reset sie/spie/spp/mprv", XLEN'({st_sie, st_spie, st_spp, st_mprv}), 0);
    chk("R1", "reset mcause", mcause, 0);
    chk("R1", "reset pc", pc_reset, RPC);
    chk("R1", "reset redirect", XLEN'(redir_valid), 0);

    // empty mask: delegatable-looking code still goes to Machine (R1, R2)
    do_trap("R2", 0, 5'd8, 32'h100, 1, 32'hDEAD_0001, 0);
    do_trap("R4", 0, 5'd2, 32'h200, 1, 32'h1234_5678, 0);
    set_mprv(1);
    do_mret("R7");                     // back to Machine, MPRV kept
    chk("R7", "mprv kept on return to M", XLEN'(st_mprv), 1);
    do_mret("R7");                     // to User, MPRV cleared
    chk("R7", "priv user after second mret", XLEN'(priv), XLEN'(LU));

    load_mask(32'h0000_2100);          // bits 8 and 13
    do_trap("R5", 0, 5'd8, 32'h300, 1, 32'hAAAA_0008, 0);
    chk("R5", "spp from user", XLEN'(st_spp), 0);
    do_trap("R6", 0, 5'd13, 32'h304, 0, 32'hFFFF_FFFF, 0);
    chk("R6", "stval zero without info", stval, 0);
    chk("R5", "spp from supervisor", XLEN'(st_spp), 1);
    do_trap("R11", 0, 5'd3, 32'h308, 1, 32'h0BAD_0003, 0);  // S -> M, S regs held
    set_mprv(1);
    do_mret("R7");
    do_sret("R8");
    chk("R8", "sret to supervisor", XLEN'(priv), XLEN'(LS));
    set_mprv(1);
    do_sret("R8");
    chk("R8", "sret to user, mprv cleared", XLEN'({priv, st_mprv}), XLEN'({LU, 1'b0}));

    do_trap("R4", 0, 5'd3, 32'h400, 0, 32'h0, 0);            // U -> M
    do_trap("R3", 0, 5'd8, 32'h404, 1, 32'h0000_0404, 0);    // clamped
    chk("R3", "delegated trap stays at M", XLEN'(priv), XLEN'(LM));
    do_mret("R7");
    do_mret("R7");                                           // to U
    do_trap("R2", 1, 5'd9, 32'h500, 0, 32'h0, 1);            // interrupt to S
    chk("R2", "interrupt flag in scause", XLEN'(scause[31]), 1);
    do_trap("R4", 1, 5'd7, 32'h504, 0, 32'h0, 0);            // interrupt to M
    chk("R4", "interrupt flag in mcause", XLEN'(mcause[31]), 1);

    repeat (3) @(negedge clk);
    chk("R9", "all redirects seen", q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule